// File: doc/BRIEF.md
# Partial Product Reduction Multiplier

This block is a purely combinational multiplier for two unsigned operands of `OP_W` bits each, 8 by default. Each bit of the multiplier selects a copy of the multiplicand through AND gates, and that copy is placed at the bit's weight. The result is a matrix of summand rows, one row for each multiplier bit.

The rows then pass through a chain of reduction stages. Each stage takes the rows in groups of three. Inside a group, every column holds a 3-2 counter where three summand bits can be set, a 2-2 counter where only two can be set, and a plain wire where only one can be set. The sum of a counter stays in its own column and its carry moves up one column. Rows left over from the grouping go straight to the next stage. At the default width the eight rows become six, then four, then three, then two. A parallel-prefix carry-lookahead adder of width 2·`OP_W` adds the last two rows into the product.

The unit has no clock and no state. Its use is as a single-cycle multiply stage in a datapath that registers the operands and the product outside the block.

Top module: `ppr_mult`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `mcand` × `mplier` as an unsigned 2·OP_W-bit value.
- R2: When either operand is zero, `product` is zero.
- R3: When both operands are all ones, `product` is (2^OP_W − 1)², which is 0xFE01 at OP_W = 8.
- R4: Operand 0b01011 (11) times 0b11001 (25) gives 0b100010011 (275).
- R5: Summand row r is the multiplicand shifted left by r when bit r of `mplier` is 1, and zero otherwise. Every bit a counter treats as structurally zero really is zero. A multiplier of one set bit at position r gives `mcand` shifted left by r.
- R6: Each reduction stage keeps the sum of its rows modulo 2^(2·OP_W). The rows are cut to 2·floor(R/3) + (R mod 3), and only two rows feed the final adder.
- R7: No carry is lost. The counter carry out of column 2·OP_W−1 and the final adder's carry out are always zero, so products that reach the top column are exact.
- R8: The final carry-lookahead add is exact when a carry has to travel across most of the product width.
- R9: The output follows an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | OP_W | Unsigned multiplicand |
| mplier | input | OP_W | Unsigned multiplier; each bit selects one summand row |
| product | output | 2*OP_W | Unsigned product |

## Verification
The hardest cases to reach are the ones that press on the reduction tree's bookkeeping. One is a column where a counter treats an input as structurally zero. Another is a carry leaving the top column. A third is a final carry chain that runs almost the full width. No single operand pattern reaches all of these. The stimulus therefore sweeps every operand pair at the default width, so every column of every counter sees every reachable input combination. Directed vectors then add the all-ones operands, single-bit multipliers and top-column products, each named after the requirement it targets.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  // number of rows left after s reduction stages, starting from n rows
  function automatic int rows_at(int n, int s);
    int r;
    r = n;
    for (int i = 0; i < s; i++) begin
      if (r > 2) r = 2 * (r / 3) + (r % 3);
    end
    return r;
  endfunction

  // stages needed to bring n rows down to two
  function automatic int num_stages(int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      c++;
    end
    return c;
  endfunction

  // lowest column in which row r of stage s can hold a one
  function automatic int row_lsb(int n, int s, int r);
    int cur [64];
    int nxt [64];
    int rr, g, x, y, z, mn, mx, md;
    for (int i = 0; i < 64; i++) begin
      cur[i] = i;
      nxt[i] = 0;
    end
    for (int st = 0; st < s; st++) begin
      rr = rows_at(n, st);
      g  = rr / 3;
      for (int k = 0; k < g; k++) begin
        x  = cur[3*k];
        y  = cur[3*k+1];
        z  = cur[3*k+2];
        mn = (x < y) ? ((x < z) ? x : z) : ((y < z) ? y : z);
        mx = (x > y) ? ((x > z) ? x : z) : ((y > z) ? y : z);
        md = x + y + z - mn - mx;
        nxt[2*k]   = mn;
        nxt[2*k+1] = md + 1;
      end
      for (int q = 0; q < rr % 3; q++) nxt[2*g+q] = cur[3*g+q];
      for (int i = 0; i < 64; i++) cur[i] = nxt[i];
    end
    return cur[r];
  endfunction

  // which of the three inputs of counter (group k, column col) can be set
  function automatic logic [2:0] active_mask(int n, int s, int k, int col);
    logic [2:0] m;
    for (int q = 0; q < 3; q++) m[q] = (row_lsb(n, s, 3*k+q) <= col);
    return m;
  endfunction

endpackage

// File: rtl/ppr_ppgen.sv
module ppr_ppgen #(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]                mcand,
  input  logic [OP_W-1:0]                mplier,
  output logic [OP_W-1:0][2*OP_W-1:0]    rows
);
  localparam int W = 2 * OP_W;

  for (genvar r = 0; r < OP_W; r++) begin : g_row
    logic [W-1:0] gated;
    assign gated   = {{OP_W{1'b0}}, mcand & {OP_W{mplier[r]}}};
    assign rows[r] = gated << r;
  end
endmodule

// File: rtl/ppr_counter.sv
module ppr_counter #(
  parameter logic [2:0] ACT = 3'b111
) (
  input  logic [2:0] bits_in,
  output logic       sum_o,
  output logic       carry_o
);
  localparam int NACT = int'(ACT[0]) + int'(ACT[1]) + int'(ACT[2]);
  localparam int LO   = ACT[0] ? 0 : (ACT[1] ? 1 : 2);
  localparam int HI   = ACT[2] ? 2 : (ACT[1] ? 1 : 0);

  if (NACT == 3) begin : g_full
    assign sum_o   = bits_in[0] ^ bits_in[1] ^ bits_in[2];
    assign carry_o = (bits_in[0] & bits_in[1]) | (bits_in[2] & (bits_in[0] ^ bits_in[1]));
  end else if (NACT == 2) begin : g_half
    assign sum_o   = bits_in[LO] ^ bits_in[HI];
    assign carry_o = bits_in[LO] & bits_in[HI];
  end else if (NACT == 1) begin : g_wire
    assign sum_o   = bits_in[LO];
    assign carry_o = 1'b0;
  end else begin : g_none
    assign sum_o   = 1'b0;
    assign carry_o = 1'b0;
  end

  // inputs marked structurally zero must never carry a one
  always_comb begin
    if (!$isunknown(bits_in))
      AST_IDLE_INPUT_ZERO: assert ((bits_in & ~ACT) == 3'b000)
        else $error("idle counter input set"); // R5
  end
endmodule

// File: rtl/ppr_stage.sv
module ppr_stage
  import ppr_pkg::*;
#(
  parameter int N = 8,
  parameter int S = 0
) (
  input  logic [N-1:0][2*N-1:0] rows_in,
  output logic [N-1:0][2*N-1:0] rows_out
);
  localparam int W    = 2 * N;
  localparam int RIN  = rows_at(N, S);
  localparam int G    = RIN / 3;
  localparam int LEFT = RIN % 3;

  logic [G-1:0][W-1:0] sum_r;
  logic [G-1:0][W-1:0] car_r;
  logic [G-1:0]        lost_carry;
  logic [W-1:0]        acc_in;
  logic [W-1:0]        acc_out;

  for (genvar k = 0; k < G; k++) begin : g_grp
    for (genvar j = 0; j < W; j++) begin : g_col
      ppr_counter #(.ACT(active_mask(N, S, k, j))) u_cell (
        .bits_in ({rows_in[3*k+2][j], rows_in[3*k+1][j], rows_in[3*k][j]}),
        .sum_o   (sum_r[k][j]),
        .carry_o (car_r[k][j])
      );
    end
    assign lost_carry[k] = car_r[k][W-1];
  end

  always_comb begin
    rows_out = '0;
    for (int k = 0; k < G; k++) begin
      rows_out[2*k]   = sum_r[k];
      rows_out[2*k+1] = {car_r[k][W-2:0], 1'b0};
    end
    for (int q = 0; q < LEFT; q++) rows_out[2*G+q] = rows_in[3*G+q];
  end

  always_comb begin
    acc_in  = '0;
    acc_out = '0;
    for (int r = 0; r < N; r++) begin
      acc_in  = acc_in + rows_in[r];
      acc_out = acc_out + rows_out[r];
    end
    if (!$isunknown(rows_in)) begin
      AST_STAGE_SUM_KEPT: assert (acc_in == acc_out)
        else $error("stage changed the row sum"); // R6
      AST_NO_LOST_CARRY: assert (lost_carry == '0)
        else $error("carry left the top column"); // R7
    end
  end
endmodule

// File: rtl/ppr_cla.sv
module ppr_cla #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  localparam int L = $clog2(W);

  logic [L:0][W-1:0] gg;
  logic [L:0][W-1:0] pp;
  logic              unused_prop;

  assign gg[0] = x & y;
  assign pp[0] = x ^ y;

  for (genvar lv = 0; lv < L; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gg[lv+1][i] = gg[lv][i] | (pp[lv][i] & gg[lv][i-D]);
        assign pp[lv+1][i] = pp[lv][i] & pp[lv][i-D];
      end else begin : g_pass
        assign gg[lv+1][i] = gg[lv][i];
        assign pp[lv+1][i] = pp[lv][i];
      end
    end
  end

  assign sum         = pp[0] ^ {gg[L][W-2:0], 1'b0};
  assign carry_out   = gg[L][W-1];
  assign unused_prop = ^pp[L];
endmodule

// File: rtl/ppr_mult.sv
module ppr_mult
  import ppr_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic [2*OP_W-1:0] product
);
  localparam int W   = 2 * OP_W;
  localparam int NST = num_stages(OP_W);

  logic [OP_W-1:0][W-1:0] tree [NST+1];
  logic                   final_cout;
  logic                   extra_rows;

  ppr_ppgen #(.OP_W(OP_W)) u_pp (
    .mcand  (mcand),
    .mplier (mplier),
    .rows   (tree[0])
  );

  for (genvar s = 0; s < NST; s++) begin : g_stage
    ppr_stage #(.N(OP_W), .S(s)) u_stage (
      .rows_in  (tree[s]),
      .rows_out (tree[s+1])
    );
  end

  ppr_cla #(.W(W)) u_cla (
    .x         (tree[NST][0]),
    .y         (tree[NST][1]),
    .sum       (product),
    .carry_out (final_cout)
  );

  always_comb begin
    extra_rows = 1'b0;
    for (int r = 2; r < OP_W; r++) extra_rows = extra_rows | (|tree[NST][r]);
    if (!$isunknown({mcand, mplier})) begin
      AST_TWO_ROWS_LEFT: assert (!extra_rows)
        else $error("more than two rows reach the adder"); // R6
      AST_FINAL_NO_CARRY: assert (!final_cout)
        else $error("final adder overflowed"); // R7
      AST_PRODUCT_MATCH: assert (product == W'(mcand) * W'(mplier))
        else $error("product mismatch"); // R1
    end
  end
endmodule

// File: tb/ppr_mult_bench.sv
module ppr_mult_bench;
  localparam int OP_W = 8;
  localparam int W    = 2 * OP_W;

  logic            clk;
  logic            rst;
  logic [OP_W-1:0] mcand;
  logic [OP_W-1:0] mplier;
  logic [W-1:0]    product;

  int checks;
  int errors;
  int cycles;
  bit done;
  int exp_q[$];

  ppr_mult #(.OP_W(OP_W)) u_ppr_mult (
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, int got, int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s got %0d expected %0d (a=%0d b=%0d)", tag, got, want, mcand, mplier);
    end
  endtask

  // reference model: one expected value per cycle, compared at the falling edge
  task automatic apply(string tag, int x, int y);
    @(posedge clk);
    #1;
    mcand  = OP_W'(x);
    mplier = OP_W'(y);
    exp_q.push_back((x * y) % (1 << W));
    @(negedge clk);
    check(tag, int'(product), exp_q.pop_front());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst    = 1'b1;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset zero operands", int'(product), 0);
    rst = 1'b0;

    apply("R4 test vector", 'b01011, 'b11001);
    check("R4 value 275", int'(product), 275);
    apply("R3 all ones", 255, 255);
    check("R3 value 0xFE01", int'(product), 'hFE01);
    apply("R2 zero multiplier", 173, 0);
    apply("R2 zero multiplicand", 0, 91);

    for (int r = 0; r < OP_W; r++) apply("R5 single-bit multiplier", 201, 1 << r);
    apply("R5 single-bit multiplicand", 1, 255);
    apply("R6 dense multiplier rows", 170, 255);
    apply("R6 sparse alternating rows", 85, 170);
    apply("R7 top column reached", 255, 129);
    apply("R7 top column reached", 254, 255);
    apply("R8 long carry chain", 255, 1);
    apply("R8 long carry chain", 129, 127);
    apply("R8 long carry chain", 128, 255);

    // R9: change inputs between clock edges and look again shortly after
    @(negedge clk);
    mcand  = 8'd19;
    mplier = 8'd23;
    #0.5;
    check("R9 no clock needed", int'(product), 19 * 23);
    mplier = 8'd200;
    #0.5;
    check("R9 follows second change", int'(product), 19 * 200);

    for (int ia = 0; ia < (1 << OP_W); ia++) begin
      for (int ib = 0; ib < (1 << OP_W); ib++) begin
        if (ia == 0 || ib == 0) apply("R2 sweep zero", ia, ib);
        else if (ia == 255 && ib == 255) apply("R3 sweep max", ia, ib);
        else apply("R1 sweep", ia, ib);
      end
    end
    finish_run();
  end
endmodule